// File: doc/BRIEF.md
# Masked Memory Poll Wait Unit

This unit sits on a 32-bit command word stream and stalls it until a location in memory meets a run-time selected condition. A wait packet is a type-3 header followed by six payload words: a control word, a 64-bit address split into low and high halves, a reference value, an AND mask, and an interval word. Once the packet is captured, the unit reads the location through a request/response memory port and masks the returned value. It then compares the result with the reference. While the condition fails, it sleeps for the programmed number of clock cycles and reads again.

The stream stays blocked while polling. The unit releases it when the comparison passes, or when an optional retry cap runs out, which raises a one-cycle timeout strobe. Headers of any other kind are skipped by their payload count. A wait packet whose control word asks for something this unit does not do is consumed at once and flagged.

Top module: `pollwait_unit`

## Requirements
- R1: A header with bits 31:30 equal to 3, opcode bits 15:8 equal to 0x3C and count bits 29:16 equal to 5 starts a wait packet. The six words that follow are, in order: control, address low, address high, reference, mask and interval. Any other header is dropped together with the next count+1 words, and no memory read or flag results from those words.
- R2: Every read is issued at the 64-bit address {address high, address low}, with address bits 1:0 forced to zero.
- R3: The value read is ANDed with the mask and compared, unsigned, against the reference. The control word bits 2:0 choose the test: 0 always, 1 value<ref, 2 value<=ref, 3 equal, 4 not equal, 5 value>=ref, 6 value>ref. A passing read gives a one-cycle waitDone strobe in the next cycle, in which cmdReady is again high.
- R4: After a failing read, memReqValid stays low for exactly the number of cycles in interval word bits 15:0 before the next request. An interval of zero gives a request in the very next cycle.
- R5: A nonzero retry limit in interval word bits 27:16 ends the wait after that many failing reads, with a one-cycle waitTimeout strobe and no further request. A limit of zero polls without end. A read that passes on the last permitted poll counts as success, not timeout.
- R6: Compare code 7, control bit 4 equal to 0 (register space) or control bit 6 equal to 1 (write-then-wait) marks the packet illegal. The unit gives a one-cycle cmdError strobe, issues no read and accepts the next header at once.
- R7: From the cycle after the last payload word is accepted until release, busy is high and cmdReady is low.
- R8: A request with memReqReady low is held, with the same address, until it is accepted.
- R9: After reset cmdReady is high, and busy, memReqValid and all three strobes are low.
- R10: Control bit 8 has no effect on the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word valid |
| cmdData | input | 32 | Command word |
| cmdReady | output | 1 | Command word accepted when high with cmdValid |
| memReqValid | output | 1 | Read request valid |
| memReqAddr | output | 64 | Read address, dword aligned |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data valid (one per accepted request) |
| memRspData | input | 32 | Read data |
| busy | output | 1 | Polling in progress, stream stalled |
| waitDone | output | 1 | One-cycle strobe: condition met |
| waitTimeout | output | 1 | One-cycle strobe: retry limit reached |
| cmdError | output | 1 | One-cycle strobe: illegal wait packet consumed |

## Verification
The critical coincidence is a passing read that lands on the last poll allowed by the retry limit. On that response, the success and timeout decisions are both live. The bench sets a limit of two and makes the second read pass, and the scoreboard requires waitDone with two reads and no timeout strobe. The same memory model also places a read response next to a stalled request (memReqReady driven from a pseudo-random pattern), and the bench measures the idle gap against the interval on every failing read.

// File: rtl/pollwait_pkg.sv
package pollwait_pkg;

  localparam logic [1:0]  PKT_TYPE3    = 2'd3;
  localparam logic [7:0]  OPC_WAIT     = 8'h3C;
  localparam logic [13:0] WAIT_COUNT   = 14'd5;
  localparam int          PAYLOAD_LEN  = 6;
  localparam int          RETRY_LSB    = 16;

  typedef enum logic [2:0] {
    CMP_ALWAYS = 3'd0,
    CMP_LT     = 3'd1,
    CMP_LE     = 3'd2,
    CMP_EQ     = 3'd3,
    CMP_NE     = 3'd4,
    CMP_GE     = 3'd5,
    CMP_GT     = 3'd6,
    CMP_BAD    = 3'd7
  } cmpFunc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capEn;
    logic [2:0] capIdx;
    logic       gapLoad;
    logic       gapDec;
    logic       failClr;
    logic       failInc;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic        hdrMatch;
    logic [13:0] hdrCount;
    logic        badCtrl;
    logic        cmpPass;
    logic        gapLast;
    logic        intvZero;
    logic        retryHit;
  } dpStat_t;

endpackage

// File: rtl/pollwait_datapath.sv
module pollwait_datapath
  import pollwait_pkg::*;
#(
  parameter int INTV_W  = 16,
  parameter int RETRY_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cmdData,
  input  logic [31:0] rspData,
  input  dpCtl_t      ctl,
  output dpStat_t     stat,
  output logic [63:0] reqAddr
);

  localparam int CNT_W = RETRY_W + 1;

  logic [2:0]         funcQ;
  logic               spaceQ;
  logic               opQ;
  logic [31:0]        addrLoQ;
  logic [31:0]        addrHiQ;
  logic [31:0]        refQ;
  logic [31:0]        maskQ;
  logic [INTV_W-1:0]  intvQ;
  logic [RETRY_W-1:0] retryLimQ;
  logic [RETRY_W-1:0] failCntQ;
  logic [INTV_W-1:0]  gapCntQ;
  logic [31:0]        masked;
  logic [CNT_W-1:0]   failNext;

  // payload capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      funcQ     <= '0;
      spaceQ    <= 1'b0;
      opQ       <= 1'b0;
      addrLoQ   <= '0;
      addrHiQ   <= '0;
      refQ      <= '0;
      maskQ     <= '0;
      intvQ     <= '0;
      retryLimQ <= '0;
    end else if (ctl.capEn) begin
      case (ctl.capIdx)
        3'd0: begin
          funcQ  <= cmdData[2:0];
          spaceQ <= cmdData[4];
          opQ    <= cmdData[6];
        end
        3'd1: addrLoQ <= {cmdData[31:2], 2'b00};
        3'd2: addrHiQ <= cmdData;
        3'd3: refQ    <= cmdData;
        3'd4: maskQ   <= cmdData;
        3'd5: begin
          intvQ     <= cmdData[INTV_W-1:0];
          retryLimQ <= cmdData[RETRY_LSB +: RETRY_W];
        end
        default: ;
      endcase
    end
  end

  // failed-poll and gap counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      failCntQ <= '0;
      gapCntQ  <= '0;
    end else begin
      if (ctl.failClr)      failCntQ <= '0;
      else if (ctl.failInc) failCntQ <= failCntQ + 1'b1;
      if (ctl.gapLoad)      gapCntQ  <= intvQ;
      else if (ctl.gapDec)  gapCntQ  <= gapCntQ - 1'b1;
    end
  end

  assign masked   = rspData & maskQ;
  assign failNext = {1'b0, failCntQ} + CNT_W'(1);

  always_comb begin
    case (cmpFunc_e'(funcQ))
      CMP_ALWAYS: stat.cmpPass = 1'b1;
      CMP_LT:     stat.cmpPass = masked <  refQ;
      CMP_LE:     stat.cmpPass = masked <= refQ;
      CMP_EQ:     stat.cmpPass = masked == refQ;
      CMP_NE:     stat.cmpPass = masked != refQ;
      CMP_GE:     stat.cmpPass = masked >= refQ;
      CMP_GT:     stat.cmpPass = masked >  refQ;
      default:    stat.cmpPass = 1'b0;
    endcase
  end

  assign stat.hdrMatch = (cmdData[31:30] == PKT_TYPE3) &&
                         (cmdData[15:8]  == OPC_WAIT) &&
                         (cmdData[29:16] == WAIT_COUNT);
  assign stat.hdrCount = cmdData[29:16];
  assign stat.badCtrl  = (funcQ == CMP_BAD) || !spaceQ || opQ;
  assign stat.gapLast  = gapCntQ <= INTV_W'(1);
  assign stat.intvZero = intvQ == '0;
  assign stat.retryHit = (retryLimQ != '0) && (failNext == {1'b0, retryLimQ});

  assign reqAddr = {addrHiQ, addrLoQ};

endmodule

// File: rtl/pollwait_ctrl.sv
module pollwait_ctrl
  import pollwait_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  output logic    cmdReady,
  output logic    memReqValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    busy,
  output logic    waitDone,
  output logic    waitTimeout,
  output logic    cmdError
);

  localparam logic [13:0] LAST_IDX = 14'(PAYLOAD_LEN - 1);

  typedef enum logic [2:0] {
    ST_HDR, ST_SKIP, ST_CAPT, ST_REQ, ST_RSP, ST_GAP
  } state_e;

  state_e      st;
  logic [13:0] wordCnt;
  logic        accept;
  logic        lastWord;
  logic        rspFail;

  assign cmdReady    = (st == ST_HDR) || (st == ST_SKIP) || (st == ST_CAPT);
  assign busy        = (st == ST_REQ) || (st == ST_RSP) || (st == ST_GAP);
  assign memReqValid = (st == ST_REQ);
  assign accept      = cmdValid && cmdReady;
  assign lastWord    = wordCnt == LAST_IDX;
  assign rspFail     = (st == ST_RSP) && memRspValid && !stat.cmpPass;

  always_comb begin
    ctl         = '0;
    ctl.capEn   = (st == ST_CAPT) && accept;
    ctl.capIdx  = wordCnt[2:0];
    ctl.failClr = (st == ST_CAPT) && accept && lastWord;
    ctl.failInc = rspFail;
    ctl.gapLoad = rspFail && !stat.retryHit && !stat.intvZero;
    ctl.gapDec  = (st == ST_GAP) && !stat.gapLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st          <= ST_HDR;
      wordCnt     <= '0;
      waitDone    <= 1'b0;
      waitTimeout <= 1'b0;
      cmdError    <= 1'b0;
    end else begin
      waitDone    <= 1'b0;
      waitTimeout <= 1'b0;
      cmdError    <= 1'b0;
      case (st)
        ST_HDR: if (accept) begin
          if (stat.hdrMatch) begin
            st      <= ST_CAPT;
            wordCnt <= '0;
          end else begin
            st      <= ST_SKIP;
            wordCnt <= stat.hdrCount;
          end
        end
        ST_SKIP: if (accept) begin
          if (wordCnt == '0) st <= ST_HDR;
          else               wordCnt <= wordCnt - 14'd1;
        end
        ST_CAPT: if (accept) begin
          if (lastWord) begin
            if (stat.badCtrl) begin
              st       <= ST_HDR;
              cmdError <= 1'b1;
            end else begin
              st <= ST_REQ;
            end
          end else begin
            wordCnt <= wordCnt + 14'd1;
          end
        end
        ST_REQ: if (memReqReady) st <= ST_RSP;
        ST_RSP: if (memRspValid) begin
          if (stat.cmpPass) begin
            st       <= ST_HDR;
            waitDone <= 1'b1;
          end else if (stat.retryHit) begin
            st          <= ST_HDR;
            waitTimeout <= 1'b1;
          end else if (stat.intvZero) begin
            st <= ST_REQ;
          end else begin
            st <= ST_GAP;
          end
        end
        ST_GAP: if (stat.gapLast) st <= ST_REQ;
        default: st <= ST_HDR;
      endcase
    end
  end

endmodule

// File: rtl/pollwait_unit.sv
module pollwait_unit
  import pollwait_pkg::*;
#(
  parameter int INTV_W  = 16,
  parameter int RETRY_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [31:0] cmdData,
  output logic        cmdReady,
  output logic        memReqValid,
  output logic [63:0] memReqAddr,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        busy,
  output logic        waitDone,
  output logic        waitTimeout,
  output logic        cmdError
);

  dpCtl_t  ctl;
  dpStat_t stat;

  pollwait_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdReady    (cmdReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .stat        (stat),
    .ctl         (ctl),
    .busy        (busy),
    .waitDone    (waitDone),
    .waitTimeout (waitTimeout),
    .cmdError    (cmdError)
  );

  pollwait_datapath #(
    .INTV_W  (INTV_W),
    .RETRY_W (RETRY_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmdData (cmdData),
    .rspData (memRspData),
    .ctl     (ctl),
    .stat    (stat),
    .reqAddr (memReqAddr)
  );

endmodule

// File: rtl/pollwait_chk.sv
module pollwait_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdReady,
  input logic        memReqValid,
  input logic [63:0] memReqAddr,
  input logic        memReqReady,
  input logic        busy,
  input logic        waitDone,
  input logic        waitTimeout,
  input logic        cmdError
);

  // R7
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmdReady);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[1:0] == 2'b00);

  // R3
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({waitDone, waitTimeout, cmdError}));

  // R3
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitDone |-> cmdReady && !busy);

  // R5
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitTimeout |=> !waitTimeout && !memReqValid);

  // R6
  error_noread_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> !memReqValid && cmdReady);

endmodule

bind pollwait_unit pollwait_chk u_pollwait_chk (.*);

// File: tb/test_pollwait_unit.sv
`timescale 1ns/1ps
module test_pollwait_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [31:0] cmdData;
  logic        cmdReady;
  logic        memReqValid;
  logic [63:0] memReqAddr;
  logic        memReqReady;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        busy;
  logic        waitDone;
  logic        waitTimeout;
  logic        cmdError;

  always #4 clk = ~clk;

  pollwait_unit i_pollwait_unit (.*);

  typedef struct {
    int          kind;   // 0 done, 1 timeout, 2 error
    int          reads;
    string       tag;
  } expItem_t;

  expItem_t    sb[$];
  logic [31:0] memSeq[$];
  int          checks = 0;
  int          fails  = 0;
  int          readCnt = 0;
  logic [63:0] expAddr;
  int          expGap;
  bit          gapArm = 0;
  int          gapSeen;
  bit          rspPend = 0;
  logic [31:0] rspVal;
  logic [7:0]  lfsr = 8'h5B;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkHdr(input logic [1:0] typ, input logic [7:0] op,
                                        input logic [13:0] cnt);
    return {typ, cnt, op, 8'h00};
  endfunction

  function automatic bit cmpOk(input int fn, input logic [31:0] v, input logic [31:0] r);
    case (fn)
      0: return 1'b1;
      1: return v < r;
      2: return v <= r;
      3: return v == r;
      4: return v != r;
      5: return v >= r;
      6: return v > r;
      default: return 1'b0;
    endcase
  endfunction

  // independent prediction of the outcome from the requirements
  task automatic predict(input int fn, input logic [31:0] r, input logic [31:0] m,
                         input int lim, output int kind, output int reads);
    kind = 1; reads = 64;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] v;
      v = memSeq[(i < memSeq.size()) ? i : memSeq.size() - 1] & m;
      if (cmpOk(fn, v, r)) begin kind = 0; reads = i + 1; return; end
      if (lim != 0 && i + 1 == lim) begin kind = 1; reads = i + 1; return; end
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    cmdValid = 1'b1;
    cmdData  = w;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic runWait(input logic [31:0] ctrl, input logic [31:0] lo,
                         input logic [31:0] hi, input logic [31:0] r,
                         input logic [31:0] m, input logic [31:0] intv,
                         input bit legal, input string tag);
    expItem_t it;
    int k, n;
    if (legal) predict(int'(ctrl[2:0]), r, m, int'(intv[27:16]), k, n);
    else begin k = 2; n = 0; end
    it.kind = k; it.reads = n; it.tag = tag;
    sb.push_back(it);
    expAddr = {hi, lo[31:2], 2'b00};
    expGap  = int'(intv[15:0]);
    sendWord(mkHdr(2'd3, 8'h3C, 14'd5));
    sendWord(ctrl);
    sendWord(lo);
    sendWord(hi);
    sendWord(r);
    sendWord(m);
    sendWord(intv);
    if (legal) begin
      // R7: stalled right after the last payload word
      chk(busy && !cmdReady, "R7", "stall after capture", {busy, cmdReady}, 2'b10);
    end else begin
      // R6: ready for the next header at once
      chk(!busy && cmdReady, "R6", "ready after illegal", {busy, cmdReady}, 2'b01);
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  // memory model, gap monitor and scoreboard monitor
  initial begin
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (waitDone || waitTimeout || cmdError) begin
          int kind;
          kind = waitDone ? 0 : (waitTimeout ? 1 : 2);
          gapArm = 0;
          if (sb.size() == 0) begin
            chk(1'b0, "R1", "unexpected outcome", kind, 99);
          end else begin
            expItem_t it;
            it = sb.pop_front();
            chk(kind == it.kind, it.tag, "outcome kind", kind, it.kind);
            chk(readCnt == it.reads, it.tag, "read count", readCnt, it.reads);
          end
          readCnt = 0;
        end
        if (gapArm) begin
          if (memReqValid) begin
            chk(gapSeen == expGap, "R4", "idle cycles between polls", gapSeen, expGap);
            gapArm = 0;
          end else begin
            gapSeen++;
          end
        end
        if (rspPend) begin
          memRspValid = 1'b1;
          memRspData  = rspVal;
          rspPend     = 1'b0;
          gapArm      = 1;
          gapSeen     = 0;
        end else begin
          memRspValid = 1'b0;
          memRspData  = 32'hDEAD_0000;
        end
        lfsr        = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        memReqReady = lfsr[0] | lfsr[2];
        if (memReqValid && memReqReady) begin
          chk(memReqAddr == expAddr, "R2", "request address", memReqAddr, expAddr);
          rspVal  = memSeq[(readCnt < memSeq.size()) ? readCnt : memSeq.size() - 1];
          readCnt++;
          rspPend = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    cmdValid = 1'b0;
    cmdData  = '0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(cmdReady && !busy && !memReqValid && !waitDone && !waitTimeout && !cmdError,
        "R9", "reset outputs",
        {cmdReady, busy, memReqValid, waitDone, waitTimeout, cmdError}, 6'b100000);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R4: not-equal against zero, interval 2
    memSeq = '{32'h0, 32'h0, 32'h5};
    runWait(32'h14, 32'h0000_1000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_0002, 1, "R3");

    // R3: all seven compare codes on a masked value
    for (int fn = 0; fn < 7; fn++) begin
      memSeq = '{32'h140, 32'h23F, 32'h040, 32'h041};
      runWait(32'h10 | fn, 32'h0000_2000, 32'h1, 32'h40, 32'hFF, 32'h0000_0001, 1, "R3");
    end

    // R4: zero interval and a long interval
    memSeq = '{32'h0, 32'h0, 32'h0, 32'h7};
    runWait(32'h14, 32'h0000_3000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 1, "R4");
    memSeq = '{32'h0, 32'h9};
    runWait(32'h14, 32'h0000_3004, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_0007, 1, "R4");

    // R5: timeout after three failing polls
    memSeq = '{32'h0};
    runWait(32'h14, 32'h0000_4000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0003_0004, 1, "R5");
    // R5: pass on the last permitted poll wins over timeout
    memSeq = '{32'h0, 32'h1};
    runWait(32'h14, 32'h0000_4000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0002_0001, 1, "R5");
    // R5: limit zero keeps polling
    memSeq = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h3};
    runWait(32'h14, 32'h0000_4000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_0001, 1, "R5");

    // R6: illegal code, register space, write-then-wait
    memSeq = '{32'h1};
    runWait(32'h17, 32'h0000_5000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h1, 0, "R6");
    runWait(32'h04, 32'h0000_5000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h1, 0, "R6");
    runWait(32'h54, 32'h0000_5000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h1, 0, "R6");

    // R1: foreign headers are skipped, including wait-looking payload words
    sendWord(mkHdr(2'd2, 8'h3C, 14'd3));
    for (int i = 0; i < 4; i++) sendWord(mkHdr(2'd3, 8'h3C, 14'd5));
    sendWord(mkHdr(2'd3, 8'h37, 14'd1));
    sendWord(32'h14);
    sendWord(32'h0);
    sendWord(mkHdr(2'd3, 8'h3C, 14'd4));
    for (int i = 0; i < 5; i++) sendWord(32'h17);
    repeat (3) @(negedge clk);
    chk(readCnt == 0 && !busy, "R1", "no read from skipped words", readCnt, 0);
    memSeq = '{32'h0, 32'h2};
    runWait(32'h14, 32'h0000_6000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h1, 1, "R1");

    // R10: engine bit ignored
    memSeq = '{32'h8, 32'h3};
    runWait(32'h113, 32'h0000_7000, 32'h0, 32'h3, 32'hF, 32'h2, 1, "R10");

    // R2: low address bits forced to zero
    memSeq = '{32'h1};
    runWait(32'h14, 32'h1234_5677, 32'hABCD_0001, 32'h0, 32'hFFFF_FFFF, 32'h1, 1, "R2");

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule